// File: doc/BRIEF.md
# Serial Test Port Controller with Boundary Chain

This block is the serial test port of a memory device, with the usual four signals TCK, TMS, TDI and TDO. A sixteen-state controller advances on every rising edge of `tck` as `tms` directs. It steers serial data from `tdi` through either the instruction register or one of three data registers. The data registers are a 32-bit identification word, a one-bit bypass stage and a 109-cell boundary chain. Serial data leaves on `tdo`, which is updated on the falling edge of `tck` and enabled only while a shift state is active.

The boundary chain reads the device pins from a parallel sample bus, `pin_sample`. It presents its update stage on a parallel drive bus, `pin_drive`. The `extest_active` flag goes high while the external-test instruction is current, and the pad logic uses it to let `pin_drive` take over the pins. The port is a serial control interface, so it has no valid/ready handshake and never applies back-pressure. Every bit is consumed on the `tck` edge that presents it. The asynchronous active-low `trst_n` puts the controller into its reset state.

Top module: `scan_port_ctrl`

## Requirements
- R1: While `trst_n` is low, the controller is in Test-Logic-Reset, the current instruction is IDCODE, `tdo_oe` is 0, `pin_drive` is all zeros and `extest_active` is 0.
- R2: Five consecutive rising `tck` edges with `tms` high reach Test-Logic-Reset from any state. Each rising edge spent in that state makes IDCODE the current instruction.
- R3: In Capture-IR the 3-bit instruction shift stage loads 001, and the bits shift out LSB first (1, 0, 0). A shifted instruction becomes current only on the rising edge taken in Update-IR.
- R4: The opcodes are 000 external test, 001 IDCODE and 100 sample/preload. Opcode 111 and every other value select the bypass stage.
- R5: Under IDCODE, Capture-DR loads the 32-bit identification value. Its default is 0x0A5C6093, and it shifts out LSB first.
- R6: The bypass stage captures 0 in Capture-DR. During Shift-DR, `tdo` then repeats `tdi` one bit later.
- R7: Under sample/preload, Capture-DR loads `pin_sample`, and bit 0 appears first on `tdo`. After 109 shifts, the bit shifted in k-th (counting from 0) sits in cell k. Update-DR copies the chain to `pin_drive`.
- R8: Under external test, `extest_active` is 1. Capture and update work as in R7.
- R9: `pin_drive` changes only on a rising edge taken in Update-DR while external test or sample/preload is current. Other instructions and other states leave it unchanged.
- R10: `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is 1 exactly from the falling edge after entry into Shift-DR or Shift-IR until the falling edge after leaving that state.
- R11: Passing through Exit1-DR, Pause-DR and Exit2-DR back to Shift-DR keeps the partly shifted register. Shifting resumes with the next unshifted bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo`, high only in shift states |
| pin_sample | input | 109 | Parallel pin values captured by the boundary chain |
| pin_drive | output | 109 | Boundary update stage, driven onto pins under external test |
| extest_active | output | 1 | High while external test is the current instruction |

## Verification
Each serial bit shifts on a rising edge and appears on `tdo` at the next falling edge. The first captured bit appears at the falling edge right after the rising edge that enters Shift-DR or Shift-IR. `pin_drive` and the current instruction settle on the rising edge taken in Update-DR or Update-IR, half a cycle before that falling edge. The bench changes `tms` and `tdi` just after a falling edge and samples every output half a nanosecond after the next falling edge. Every update is therefore already visible when it is sampled. One scenario also samples `tdo` just after a rising edge to confirm that the value has not yet moved.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  typedef enum logic [3:0] {
    ST_TLR,
    ST_RTI,
    ST_SEL_DR,
    ST_CAP_DR,
    ST_SH_DR,
    ST_EX1_DR,
    ST_PAU_DR,
    ST_EX2_DR,
    ST_UPD_DR,
    ST_SEL_IR,
    ST_CAP_IR,
    ST_SH_IR,
    ST_EX1_IR,
    ST_PAU_IR,
    ST_EX2_IR,
    ST_UPD_IR
  } tap_state_t;

  localparam int unsigned DEF_IR_W    = 3;
  localparam int unsigned DEF_ID_W    = 32;
  localparam int unsigned DEF_BSR_LEN = 109;

endpackage

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
  import scan_port_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);

  tap_state_t nxt;

  always_comb begin
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= nxt;
  end

endmodule

// File: rtl/scan_port_ir.sv
module scan_port_ir
  import scan_port_pkg::*;
#(
  parameter int unsigned     IR_W    = DEF_IR_W,
  parameter logic [IR_W-1:0] RST_OP  = IR_W'(1),
  parameter logic [IR_W-1:0] CAP_PAT = IR_W'(1)
) (
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic            sout,
  output logic [IR_W-1:0] ir_cur
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr  <= CAP_PAT;
      ir_cur <= RST_OP;
    end else begin
      unique case (state)
        ST_CAP_IR: ir_sr  <= CAP_PAT;
        ST_SH_IR:  ir_sr  <= {tdi, ir_sr[IR_W-1:1]};
        ST_UPD_IR: ir_cur <= ir_sr;
        ST_TLR:    ir_cur <= RST_OP;
        default:   ;
      endcase
    end
  end

  assign sout = ir_sr[0];

endmodule

// File: rtl/scan_port_shreg.sv
module scan_port_shreg #(
  parameter int unsigned  W       = 32,
  parameter logic [W-1:0] CAP_VAL = '0
) (
  input  logic tck,
  input  logic trst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic sin,
  output logic sout
);

  logic [W-1:0] sreg;
  logic [W-1:0] shifted;

  generate
    if (W == 1) begin : g_single
      assign shifted = sin;
    end else begin : g_multi
      assign shifted = {sin, sreg[W-1:1]};
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       sreg <= '0;
    else if (cap_en)   sreg <= CAP_VAL;
    else if (shift_en) sreg <= shifted;
  end

  assign sout = sreg[0];

endmodule

// File: rtl/scan_port_bsr.sv
module scan_port_bsr #(
  parameter int unsigned LEN = 109
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           cap_en,
  input  logic           shift_en,
  input  logic           upd_en,
  input  logic           sin,
  input  logic [LEN-1:0] pin_sample,
  output logic           sout,
  output logic [LEN-1:0] pin_drive
);

  logic [LEN-1:0] chain;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       chain <= '0;
    else if (cap_en)   chain <= pin_sample;
    else if (shift_en) chain <= {sin, chain[LEN-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     pin_drive <= '0;
    else if (upd_en) pin_drive <= chain;
  end

  assign sout = chain[0];

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_port_pkg::*;
#(
  parameter int unsigned     IR_W       = DEF_IR_W,
  parameter int unsigned     ID_W       = DEF_ID_W,
  parameter int unsigned     BSR_LEN    = DEF_BSR_LEN,
  parameter logic [ID_W-1:0] ID_VALUE   = 32'h0A5C_6093,
  parameter logic [IR_W-1:0] OP_EXTEST  = 3'b000,
  parameter logic [IR_W-1:0] OP_IDCODE  = 3'b001,
  parameter logic [IR_W-1:0] OP_SAMPLE  = 3'b100
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pin_sample,
  output logic [BSR_LEN-1:0] pin_drive,
  output logic               extest_active
);

  localparam logic [IR_W-1:0] IR_CAP = IR_W'(1);

  tap_state_t      state;
  logic [IR_W-1:0] ir_cur;
  logic            ir_so, id_so, byp_so, bsr_so, dr_so;
  logic            sel_id, sel_bsr;
  logic            cap_dr, sh_dr, upd_dr, sh_ir;

  scan_port_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  scan_port_ir #(
    .IR_W    (IR_W),
    .RST_OP  (OP_IDCODE),
    .CAP_PAT (IR_CAP)
  ) u_ir (
    .tck    (tck),
    .trst_n (trst_n),
    .state  (state),
    .tdi    (tdi),
    .sout   (ir_so),
    .ir_cur (ir_cur)
  );

  assign sel_id  = (ir_cur == OP_IDCODE);
  assign sel_bsr = (ir_cur == OP_EXTEST) || (ir_cur == OP_SAMPLE);
  assign cap_dr  = (state == ST_CAP_DR);
  assign sh_dr   = (state == ST_SH_DR);
  assign upd_dr  = (state == ST_UPD_DR);
  assign sh_ir   = (state == ST_SH_IR);

  scan_port_shreg #(
    .W       (ID_W),
    .CAP_VAL (ID_VALUE)
  ) u_id (
    .tck      (tck),
    .trst_n   (trst_n),
    .cap_en   (cap_dr && sel_id),
    .shift_en (sh_dr && sel_id),
    .sin      (tdi),
    .sout     (id_so)
  );

  scan_port_shreg #(
    .W       (1),
    .CAP_VAL (1'b0)
  ) u_byp (
    .tck      (tck),
    .trst_n   (trst_n),
    .cap_en   (cap_dr && !sel_id && !sel_bsr),
    .shift_en (sh_dr && !sel_id && !sel_bsr),
    .sin      (tdi),
    .sout     (byp_so)
  );

  scan_port_bsr #(
    .LEN (BSR_LEN)
  ) u_bsr (
    .tck        (tck),
    .trst_n     (trst_n),
    .cap_en     (cap_dr && sel_bsr),
    .shift_en   (sh_dr && sel_bsr),
    .upd_en     (upd_dr && sel_bsr),
    .sin        (tdi),
    .pin_sample (pin_sample),
    .sout       (bsr_so),
    .pin_drive  (pin_drive)
  );

  assign dr_so = sel_id ? id_so : (sel_bsr ? bsr_so : byp_so);

  // Serial output is retimed to the falling edge of the test clock.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= sh_dr || sh_ir;
      tdo    <= sh_ir ? ir_so : (sh_dr ? dr_so : 1'b0);
    end
  end

  assign extest_active = (ir_cur == OP_EXTEST);

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_port_pkg::*;
#(
  parameter int unsigned     IR_W      = DEF_IR_W,
  parameter int unsigned     BSR_LEN   = DEF_BSR_LEN,
  parameter logic [IR_W-1:0] OP_IDCODE = 3'b001
) (
  input logic               tck,
  input logic               trst_n,
  input logic               tms,
  input logic               tdo_oe,
  input logic [BSR_LEN-1:0] pin_drive,
  input tap_state_t         state,
  input logic [IR_W-1:0]    ir_cur
);

  logic [2:0] ones_run;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)             ones_run <= '0;
    else if (!tms)           ones_run <= '0;
    else if (ones_run != 5)  ones_run <= ones_run + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_run == 3'd5) |-> (state == ST_TLR)); // R2

  AST_RESET_LOADS_ID: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |=> (ir_cur == OP_IDCODE)); // R2

  AST_INSTR_HELD: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_cur)); // R3

  AST_DRIVE_HELD: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_DR) |=> $stable(pin_drive)); // R9

  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (state == ST_SH_DR || state == ST_SH_IR)); // R10

endmodule

bind scan_port_ctrl scan_port_chk #(
  .IR_W      (IR_W),
  .BSR_LEN   (BSR_LEN),
  .OP_IDCODE (OP_IDCODE)
) u_chk (
  .tck       (tck),
  .trst_n    (trst_n),
  .tms       (tms),
  .tdo_oe    (tdo_oe),
  .pin_drive (pin_drive),
  .state     (state),
  .ir_cur    (ir_cur)
);

// File: tb/scan_port_ctrl_test.sv
`timescale 1ns/100ps
module scan_port_ctrl_test;

  localparam int          N   = 109;
  localparam logic [31:0] IDV = 32'h0A5C_6093;

  logic         tck = 1'b0;
  logic         trst_n = 1'b0;
  logic         tms = 1'b1;
  logic         tdi = 1'b0;
  logic [N-1:0] pin_sample = '0;
  logic         tdo, tdo_oe, extest_active;
  logic [N-1:0] pin_drive;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 tck = ~tck;

  scan_port_ctrl uut (
    .tck           (tck),
    .trst_n        (trst_n),
    .tms           (tms),
    .tdi           (tdi),
    .tdo           (tdo),
    .tdo_oe        (tdo_oe),
    .pin_sample    (pin_sample),
    .pin_drive     (pin_drive),
    .extest_active (extest_active)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs change just after a falling edge; outputs sampled just after the next one.
  task automatic tick(input logic m, input logic d, output logic o, output logic oe);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #0.5;
    o  = tdo;
    oe = tdo_oe;
  endtask

  task automatic walk(input logic m);
    logic o, e;
    tick(m, 1'b0, o, e);
  endtask

  // From Run-Test-Idle through a full scan of n bits and back to Run-Test-Idle.
  task automatic scan(input bit ir, input int n, input logic [N-1:0] din,
                      output logic [N-1:0] dout);
    logic o, e;
    dout = '0;
    walk(1'b1);
    if (ir) walk(1'b1);
    walk(1'b0);
    tick(1'b0, 1'b0, o, e);
    chk("R10 oe in shift", N'(e), N'(1));
    dout[0] = o;
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o, e);
      if (i < n - 1) dout[i+1] = o;
    end
    chk("R10 oe after shift", N'(e), N'(0));
    walk(1'b1);
    walk(1'b0);
  endtask

  task automatic t_reset;
    trst_n = 1'b0;
    #10;
    chk("R1 tdo_oe", N'(tdo_oe), N'(0));
    chk("R1 pin_drive", pin_drive, '0);
    chk("R1 extest_active", N'(extest_active), N'(0));
    @(negedge tck);
    #0.5;
    trst_n = 1'b1;
    walk(1'b0);
  endtask

  task automatic t_idcode;
    logic [N-1:0] d;
    scan(1'b0, 32, '0, d);
    chk("R5 id word", N'(d[31:0]), N'(IDV));
  endtask

  task automatic t_capture_ir;
    logic [N-1:0] d;
    scan(1'b1, 3, N'(3'b111), d);
    chk("R3 capture pattern", N'(d[2:0]), N'(3'b001));
    chk("R3 extest off", N'(extest_active), N'(0));
  endtask

  task automatic t_bypass(input string req);
    logic [N-1:0] d;
    logic [7:0] din;
    din = 8'b1011_0110;
    scan(1'b0, 8, N'(din), d);
    chk(req, N'(d[7:0]), N'({din[6:0], 1'b0}));
  endtask

  task automatic t_unused;
    logic [N-1:0] d;
    scan(1'b1, 3, N'(3'b010), d);
    t_bypass("R4 unused opcode bypass");
  endtask

  task automatic t_five_ones;
    logic [N-1:0] d;
    logic o, e;
    walk(1'b1);
    walk(1'b0);
    walk(1'b0);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o, e);
    chk("R2 oe off in reset state", N'(e), N'(0));
    walk(1'b0);
    scan(1'b0, 32, '0, d);
    chk("R2 idcode after five ones", N'(d[31:0]), N'(IDV));
  endtask

  task automatic t_sample(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N-1:0] d;
    pin_sample = a;
    scan(1'b1, 3, N'(3'b100), d);
    chk("R4 sample not extest", N'(extest_active), N'(0));
    scan(1'b0, N, b, d);
    chk("R7 captured pins", d, a);
    chk("R7 preload to drive", pin_drive, b);
  endtask

  task automatic t_extest(input logic [N-1:0] b, input logic [N-1:0] c,
                          input logic [N-1:0] dd);
    logic [N-1:0] d;
    scan(1'b1, 3, N'(3'b000), d);
    chk("R8 extest flag", N'(extest_active), N'(1));
    chk("R9 drive kept on IR update", pin_drive, b);
    pin_sample = c;
    scan(1'b0, N, dd, d);
    chk("R8 captured pins", d, c);
    chk("R8 update to drive", pin_drive, dd);
  endtask

  task automatic t_hold(input logic [N-1:0] dd);
    logic [N-1:0] d;
    scan(1'b1, 3, N'(3'b001), d);
    chk("R8 extest flag cleared", N'(extest_active), N'(0));
    scan(1'b0, 32, '1, d);
    chk("R9 drive kept under idcode", pin_drive, dd);
    chk("R5 id word again", N'(d[31:0]), N'(IDV));
  endtask

  task automatic t_pause;
    logic o, e;
    logic [3:0] got;
    walk(1'b1);
    walk(1'b0);
    tick(1'b0, 1'b0, o, e);
    got[0] = o;
    for (int i = 1; i < 4; i++) begin
      tick(1'b0, 1'b0, o, e);
      got[i] = o;
    end
    tick(1'b1, 1'b0, o, e);
    walk(1'b0);
    tick(1'b0, 1'b0, o, e);
    chk("R10 oe off in pause", N'(e), N'(0));
    walk(1'b1);
    tick(1'b0, 1'b0, o, e);
    chk("R11 first bits", N'(got), N'(IDV[3:0]));
    chk("R11 resume bit", N'(o), N'(IDV[4]));
    walk(1'b1);
    walk(1'b1);
    walk(1'b0);
  endtask

  task automatic t_edge;
    logic o, e;
    walk(1'b1);
    walk(1'b0);
    tick(1'b0, 1'b0, o, e);
    tms = 1'b0;
    tdi = 1'b0;
    @(posedge tck);
    #0.5;
    chk("R10 tdo held past rising edge", N'(tdo), N'(IDV[0]));
    @(negedge tck);
    #0.5;
    chk("R10 tdo moves on falling edge", N'(tdo), N'(IDV[1]));
    walk(1'b1);
    walk(1'b1);
    walk(1'b0);
  endtask

  initial begin
    logic [N-1:0] pa, pb, pc, pd;
    for (int k = 0; k < N; k++) begin
      pa[k] = ((k * 7 + 3) % 5) < 2;
      pb[k] = ((k * 3 + 1) % 4) == 0;
      pc[k] = (k % 3) != 1;
      pd[k] = ((k * 5 + 2) % 7) > 3;
    end
    t_reset();
    t_idcode();
    t_capture_ir();
    t_bypass("R6 bypass delay");
    t_unused();
    t_five_ones();
    t_sample(pa, pb);
    t_extest(pb, pc, pd);
    t_hold(pd);
    t_pause();
    t_edge();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule